// File: doc/BRIEF.md
# Segment Address Translator with Last-Hit Cache

This block turns a logical address into a physical address by looking it up in a table of segment descriptors. Each descriptor names a logical base, a size mask that marks which low address bits are the offset, a physical base, an address-space number and a valid bit. A requester presents an address together with a small space code. A space table, written through the register port, turns that code into the address-space number that descriptors are matched against.

Most lookups land in the same segment as the one before. So a one-entry cache keeps the number of the descriptor that last matched, and that descriptor is tried first, with a result one cycle after the request. On a cache miss a scan walks the table one descriptor per clock, from index 0 upward. It stops at the first match, so the lowest-numbered matching descriptor always wins. If nothing matches, a fault is reported.

Any change to the table or the space table empties the cache, so a stale shortcut can never bypass the priority rule. Configuration writes are expected only while no scan is running.

Top module: `seg_xlate_mmu`

## Requirements
- R1: After reset `hit_o`, `fault_o` and `pa_o` are 0, the cache is empty, and descriptor 0 is valid with address-space number 0, logical base 0, physical base 0 and a mask of all ones. Any address under any space code therefore translates to itself.
- R2: On a cache miss, descriptors are examined one per clock in ascending index order. A request sampled at edge n whose first matching descriptor is k gives `hit_o`=1 and the result in the cycle after edge n+1+k.
- R3: When several descriptors match, the result comes from the one with the lowest index.
- R4: A successful scan loads the matching index into the cache. A later request that matches the cached descriptor gives `hit_o`=1 in the cycle after its own request edge.
- R5: If none of the NUM_DESC descriptors matches, `fault_o`=1 for one cycle after edge n+NUM_DESC (n is the request edge), `hit_o` stays 0, and the cache contents are left as they were.
- R6: A descriptor load (`dl_we`=1) empties the cache.
- R7: A register write empties the cache, both for a status write (`rw_sel`=0, which sets the valid bit of descriptor `rw_idx` to `rw_data[0]`) and for a space-table write (`rw_sel`=1, which sets the entry for code `rw_idx[SC_W-1:0]` to `rw_data`).
- R8: Descriptor d matches when it is valid, its address-space number equals the looked-up one, and (addr & ~mask) == (lbase & ~mask). The physical address is then pbase | (addr & mask).
- R9: The address-space number used in a lookup is the space-table entry selected by `lk_space`. After reset every entry is 0.
- R10: `hit_o` and `fault_o` are never high together. A request raised while a scan is running is ignored: it produces no result of its own and does not disturb the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request, sampled while idle |
| lk_addr | input | ADDR_W | Logical address to translate |
| lk_space | input | SC_W | Space code, mapped to an address-space number |
| dl_we | input | 1 | Load descriptor `dl_idx` with the fields below |
| dl_idx | input | IDX_W | Descriptor index to load |
| dl_lbase | input | ADDR_W | Logical base |
| dl_mask | input | ADDR_W | Offset mask (1 = offset bit) |
| dl_pbase | input | ADDR_W | Physical base |
| dl_asn | input | ASN_W | Address-space number |
| dl_valid | input | 1 | Valid bit |
| rw_we | input | 1 | Register write strobe |
| rw_sel | input | 1 | 0 = descriptor status, 1 = space table |
| rw_idx | input | IDX_W | Descriptor index or space code |
| rw_data | input | ASN_W | Write data (bit 0 is the valid bit for status writes) |
| pa_o | output | ADDR_W | Physical address of the last hit |
| hit_o | output | 1 | Lookup completed with a translation |
| fault_o | output | 1 | Lookup found no matching descriptor |

## Verification
The hardest case to reach from the ports is a cached descriptor that has gone stale. This happens when the cache still holds an index, but a configuration write has changed which descriptor should win or which address-space number a code maps to. The bench first fills the cache with a known index. It then makes each kind of write in turn and repeats the same lookup, expecting the full scan latency instead of the single-cycle one. It also remaps a space code so that the cached descriptor no longer matches on its address-space number. Finally, a lookup is raised in the middle of a running scan to show that it is ignored.

// File: rtl/mmu_pkg.sv
// Package: shared types for the segment translator.
// Holds the controller state encoding and the register-port selector codes.
package mmu_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    localparam logic REG_SEL_STATUS = 1'b0;
    localparam logic REG_SEL_SPACE  = 1'b1;

endpackage

// File: rtl/desc_table.sv
// Module: desc_table
// Register file of segment descriptors with one full-load port, one
// valid-bit status port, and two combinational read ports (cache probe and
// scan probe). Entry 0 resets to an identity mapping; all others reset invalid.
// Assumes at most one of load/status targets a given entry per cycle (load wins).
module desc_table #(
    parameter int NUM_DESC = 32,
    parameter int ADDR_W   = 24,
    parameter int ASN_W    = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_lbase,
    input  logic [ADDR_W-1:0] ld_mask,
    input  logic [ADDR_W-1:0] ld_pbase,
    input  logic [ASN_W-1:0]  ld_asn,
    input  logic              ld_valid,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic              st_valid,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [ADDR_W-1:0] ra_lbase,
    output logic [ADDR_W-1:0] ra_mask,
    output logic [ADDR_W-1:0] ra_pbase,
    output logic [ASN_W-1:0]  ra_asn,
    output logic              ra_valid,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [ADDR_W-1:0] rb_lbase,
    output logic [ADDR_W-1:0] rb_mask,
    output logic [ADDR_W-1:0] rb_pbase,
    output logic [ASN_W-1:0]  rb_asn,
    output logic              rb_valid
);

    logic [ADDR_W-1:0] lbase_q [NUM_DESC];
    logic [ADDR_W-1:0] mask_q  [NUM_DESC];
    logic [ADDR_W-1:0] pbase_q [NUM_DESC];
    logic [ASN_W-1:0]  asn_q   [NUM_DESC];
    logic              valid_q [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
        localparam logic              RST_VALID = (g == 0);
        localparam logic [ADDR_W-1:0] RST_MASK  = (g == 0) ? '1 : '0;

        logic sel_ld;
        logic sel_st;
        assign sel_ld = ld_we && (ld_idx == IDX_W'(g));
        assign sel_st = st_we && (st_idx == IDX_W'(g));

        // Entry storage: reset value, full load, or valid-bit update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lbase_q[g] <= '0;
                mask_q[g]  <= RST_MASK;
                pbase_q[g] <= '0;
                asn_q[g]   <= '0;
                valid_q[g] <= RST_VALID;
            end else if (sel_ld) begin
                lbase_q[g] <= ld_lbase;
                mask_q[g]  <= ld_mask;
                pbase_q[g] <= ld_pbase;
                asn_q[g]   <= ld_asn;
                valid_q[g] <= ld_valid;
            end else if (sel_st) begin
                valid_q[g] <= st_valid;
            end
        end
    end

    // Read port A: descriptor selected by the cache.
    always_comb begin
        ra_lbase = lbase_q[ra_idx];
        ra_mask  = mask_q[ra_idx];
        ra_pbase = pbase_q[ra_idx];
        ra_asn   = asn_q[ra_idx];
        ra_valid = valid_q[ra_idx];
    end

    // Read port B: descriptor under the scan pointer.
    always_comb begin
        rb_lbase = lbase_q[rb_idx];
        rb_mask  = mask_q[rb_idx];
        rb_pbase = pbase_q[rb_idx];
        rb_asn   = asn_q[rb_idx];
        rb_valid = valid_q[rb_idx];
    end

endmodule

// File: rtl/space_table.sv
// Module: space_table
// Maps a small space code to an address-space number. All entries reset to 0.
// One write port, one combinational read port.
module space_table #(
    parameter int SC_W   = 3,
    parameter int ASN_W  = 8,
    localparam int NUM_SC = 1 << SC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SC_W-1:0]  wr_code,
    input  logic [ASN_W-1:0] wr_asn,
    input  logic [SC_W-1:0]  rd_code,
    output logic [ASN_W-1:0] rd_asn
);

    logic [ASN_W-1:0] map_q [NUM_SC];

    for (genvar g = 0; g < NUM_SC; g++) begin : g_code
        // Table entry: clear at reset, replace on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[g] <= '0;
            end else if (wr_en && (wr_code == SC_W'(g))) begin
                map_q[g] <= wr_asn;
            end
        end
    end

    // Lookup of the presented code.
    always_comb rd_asn = map_q[rd_code];

endmodule

// File: rtl/desc_match.sv
// Module: desc_match
// Combinational comparison of one descriptor against an address and
// address-space number; also forms the translated address.
// Assumes the mask marks offset bits with 1.
module desc_match #(
    parameter int ADDR_W = 24,
    parameter int ASN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ASN_W-1:0]  asn,
    input  logic [ADDR_W-1:0] d_lbase,
    input  logic [ADDR_W-1:0] d_mask,
    input  logic [ADDR_W-1:0] d_pbase,
    input  logic [ASN_W-1:0]  d_asn,
    input  logic              d_valid,
    output logic              match,
    output logic [ADDR_W-1:0] pa
);

    // Segment compare on the non-offset bits plus space and valid checks.
    always_comb begin
        match = d_valid && (d_asn == asn) &&
                ((addr & ~d_mask) == (d_lbase & ~d_mask));
        pa    = d_pbase | (addr & d_mask);
    end

endmodule

// File: rtl/hit_cache.sv
// Module: hit_cache
// One-entry memory of the last matching descriptor index.
// Flush takes priority over load.
module hit_cache #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    // Cache register: empty at reset and on flush, filled on a scan hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            idx   <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            idx   <= load_idx;
        end
    end

endmodule

// File: rtl/scan_ctrl.sv
// Module: scan_ctrl
// Lookup sequencer. While idle it accepts a request, answers it from the cache
// probe when that matches, and otherwise latches the request and steps a scan
// pointer through the table one entry per clock until a match or the last entry.
// Requests raised during a scan are ignored.
module scan_ctrl
    import mmu_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int ADDR_W   = 24,
    parameter int ASN_W    = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ASN_W-1:0]  lk_asn,
    input  logic              cache_hit,
    input  logic [ADDR_W-1:0] cache_pa,
    input  logic              scan_match,
    input  logic [ADDR_W-1:0] scan_pa,
    output logic [IDX_W-1:0]  scan_idx,
    output logic [ADDR_W-1:0] scan_addr,
    output logic [ASN_W-1:0]  scan_asn,
    output logic              scan_active,
    output logic              cache_load,
    output logic [ADDR_W-1:0] pa_o,
    output logic              hit_o,
    output logic              fault_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    scan_state_t state_q;

    // Scan progress and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            scan_idx  <= '0;
            scan_addr <= '0;
            scan_asn  <= '0;
            pa_o      <= '0;
            hit_o     <= 1'b0;
            fault_o   <= 1'b0;
        end else begin
            hit_o   <= 1'b0;
            fault_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (lk_req) begin
                        if (cache_hit) begin
                            pa_o  <= cache_pa;
                            hit_o <= 1'b1;
                        end else begin
                            scan_addr <= lk_addr;
                            scan_asn  <= lk_asn;
                            scan_idx  <= '0;
                            state_q   <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (scan_match) begin
                        pa_o    <= scan_pa;
                        hit_o   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (scan_idx == LAST_IDX) begin
                        fault_o <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status toward the cache and checker.
    always_comb begin
        scan_active = (state_q == ST_SCAN);
        cache_load  = scan_active && scan_match;
    end

endmodule

// File: rtl/seg_xlate_mmu.sv
// Module: seg_xlate_mmu (top)
// Segment address translator: descriptor table, space-code table, one-entry
// last-hit cache and a sequential lowest-index-first scan on cache miss.
// Assumes configuration writes are not issued while a scan is running, and
// SC_W <= IDX_W so a space code fits the register index field.
module seg_xlate_mmu
    import mmu_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int ADDR_W   = 24,
    parameter int ASN_W    = 8,
    parameter int SC_W     = 3,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SC_W-1:0]   lk_space,
    input  logic              dl_we,
    input  logic [IDX_W-1:0]  dl_idx,
    input  logic [ADDR_W-1:0] dl_lbase,
    input  logic [ADDR_W-1:0] dl_mask,
    input  logic [ADDR_W-1:0] dl_pbase,
    input  logic [ASN_W-1:0]  dl_asn,
    input  logic              dl_valid,
    input  logic              rw_we,
    input  logic              rw_sel,
    input  logic [IDX_W-1:0]  rw_idx,
    input  logic [ASN_W-1:0]  rw_data,
    output logic [ADDR_W-1:0] pa_o,
    output logic              hit_o,
    output logic              fault_o
);

    logic              cfg_we;
    logic              st_we;
    logic              sp_we;
    logic [ASN_W-1:0]  lk_asn;
    logic              cache_valid;
    logic [IDX_W-1:0]  cache_idx;
    logic              cache_load;
    logic              cache_match;
    logic              cache_hit;
    logic [ADDR_W-1:0] cache_pa;
    logic [IDX_W-1:0]  scan_idx;
    logic [ADDR_W-1:0] scan_addr;
    logic [ASN_W-1:0]  scan_asn;
    logic              scan_active;
    logic              scan_match;
    logic [ADDR_W-1:0] scan_pa;

    logic [ADDR_W-1:0] a_lbase, a_mask, a_pbase;
    logic [ASN_W-1:0]  a_asn;
    logic              a_valid;
    logic [ADDR_W-1:0] b_lbase, b_mask, b_pbase;
    logic [ASN_W-1:0]  b_asn;
    logic              b_valid;

    // Register-port decode; any configuration write flushes the cache.
    always_comb begin
        st_we  = rw_we && (rw_sel == REG_SEL_STATUS);
        sp_we  = rw_we && (rw_sel == REG_SEL_SPACE);
        cfg_we = dl_we || rw_we;
    end

    desc_table #(
        .NUM_DESC (NUM_DESC),
        .ADDR_W   (ADDR_W),
        .ASN_W    (ASN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (dl_we),
        .ld_idx   (dl_idx),
        .ld_lbase (dl_lbase),
        .ld_mask  (dl_mask),
        .ld_pbase (dl_pbase),
        .ld_asn   (dl_asn),
        .ld_valid (dl_valid),
        .st_we    (st_we),
        .st_idx   (rw_idx),
        .st_valid (rw_data[0]),
        .ra_idx   (cache_idx),
        .ra_lbase (a_lbase),
        .ra_mask  (a_mask),
        .ra_pbase (a_pbase),
        .ra_asn   (a_asn),
        .ra_valid (a_valid),
        .rb_idx   (scan_idx),
        .rb_lbase (b_lbase),
        .rb_mask  (b_mask),
        .rb_pbase (b_pbase),
        .rb_asn   (b_asn),
        .rb_valid (b_valid)
    );

    space_table #(
        .SC_W  (SC_W),
        .ASN_W (ASN_W)
    ) u_space (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sp_we),
        .wr_code (rw_idx[SC_W-1:0]),
        .wr_asn  (rw_data),
        .rd_code (lk_space),
        .rd_asn  (lk_asn)
    );

    hit_cache #(
        .IDX_W (IDX_W)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cfg_we),
        .load     (cache_load),
        .load_idx (scan_idx),
        .valid    (cache_valid),
        .idx      (cache_idx)
    );

    desc_match #(
        .ADDR_W (ADDR_W),
        .ASN_W  (ASN_W)
    ) u_match_cache (
        .addr    (lk_addr),
        .asn     (lk_asn),
        .d_lbase (a_lbase),
        .d_mask  (a_mask),
        .d_pbase (a_pbase),
        .d_asn   (a_asn),
        .d_valid (a_valid),
        .match   (cache_match),
        .pa      (cache_pa)
    );

    desc_match #(
        .ADDR_W (ADDR_W),
        .ASN_W  (ASN_W)
    ) u_match_scan (
        .addr    (scan_addr),
        .asn     (scan_asn),
        .d_lbase (b_lbase),
        .d_mask  (b_mask),
        .d_pbase (b_pbase),
        .d_asn   (b_asn),
        .d_valid (b_valid),
        .match   (scan_match),
        .pa      (scan_pa)
    );

    // A cache probe counts only when the cache is filled and not being flushed.
    always_comb cache_hit = cache_valid && !cfg_we && cache_match;

    scan_ctrl #(
        .NUM_DESC (NUM_DESC),
        .ADDR_W   (ADDR_W),
        .ASN_W    (ASN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_req      (lk_req),
        .lk_addr     (lk_addr),
        .lk_asn      (lk_asn),
        .cache_hit   (cache_hit),
        .cache_pa    (cache_pa),
        .scan_match  (scan_match),
        .scan_pa     (scan_pa),
        .scan_idx    (scan_idx),
        .scan_addr   (scan_addr),
        .scan_asn    (scan_asn),
        .scan_active (scan_active),
        .cache_load  (cache_load),
        .pa_o        (pa_o),
        .hit_o       (hit_o),
        .fault_o     (fault_o)
    );

endmodule

// File: rtl/seg_xlate_mmu_chk.sv
// Module: seg_xlate_mmu_chk
// Property checker for seg_xlate_mmu, attached by bind. It observes the scan
// pointer, the cache register and the result outputs.
module seg_xlate_mmu_chk #(
    parameter int NUM_DESC = 32,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dl_we,
    input logic             rw_we,
    input logic             hit_o,
    input logic             fault_o,
    input logic             scan_active,
    input logic             scan_match,
    input logic [IDX_W-1:0] scan_idx,
    input logic             cache_valid,
    input logic [IDX_W-1:0] cache_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    logic cfg_we;
    assign cfg_we = dl_we || rw_we;

    // R2: a scan with no match moves to the next index on the next cycle.
    assert_scan_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && !scan_match && scan_idx != LAST_IDX)
        |=> (scan_active && scan_idx == IDX_W'($past(scan_idx) + 1'b1)));

    // R4: a scan match fills the cache with the matching index.
    assert_scan_fills_cache_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && scan_match && !cfg_we)
        |=> (cache_valid && cache_idx == $past(scan_idx)));

    // R5: a fault comes only from a failed check of the last descriptor.
    assert_fault_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(scan_active && !scan_match && scan_idx == LAST_IDX));

    // R5: a fault leaves the cache register unchanged.
    assert_fault_keeps_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !$past(cfg_we))
        |-> (cache_valid == $past(cache_valid) && cache_idx == $past(cache_idx)));

    // R6/R7: any configuration write empties the cache.
    assert_cfg_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cache_valid);

    // R10: hit and fault are exclusive.
    assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && fault_o));

endmodule

bind seg_xlate_mmu seg_xlate_mmu_chk #(
    .NUM_DESC (NUM_DESC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dl_we       (dl_we),
    .rw_we       (rw_we),
    .hit_o       (hit_o),
    .fault_o     (fault_o),
    .scan_active (scan_active),
    .scan_match  (scan_match),
    .scan_idx    (scan_idx),
    .cache_valid (cache_valid),
    .cache_idx   (cache_idx)
);

// File: tb/test_seg_xlate_mmu.sv
// Bench: test_seg_xlate_mmu
// Sweeps every descriptor slot with arithmetic mappings and checks the results,
// the latencies, the priority order, the cache flush rules and the fault path.
module test_seg_xlate_mmu;

    localparam int NUM_DESC = 32;
    localparam int ADDR_W   = 24;
    localparam int ASN_W    = 8;
    localparam int SC_W     = 3;
    localparam int IDX_W    = $clog2(NUM_DESC);
    localparam int FAULT_LAT = NUM_DESC + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_req;
    logic [ADDR_W-1:0] lk_addr;
    logic [SC_W-1:0]   lk_space;
    logic              dl_we;
    logic [IDX_W-1:0]  dl_idx;
    logic [ADDR_W-1:0] dl_lbase, dl_mask, dl_pbase;
    logic [ASN_W-1:0]  dl_asn;
    logic              dl_valid;
    logic              rw_we;
    logic              rw_sel;
    logic [IDX_W-1:0]  rw_idx;
    logic [ASN_W-1:0]  rw_data;
    logic [ADDR_W-1:0] pa_o;
    logic              hit_o;
    logic              fault_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    seg_xlate_mmu #(
        .NUM_DESC (NUM_DESC),
        .ADDR_W   (ADDR_W),
        .ASN_W    (ASN_W),
        .SC_W     (SC_W)
    ) i_seg_xlate_mmu (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_addr  (lk_addr),
        .lk_space (lk_space),
        .dl_we    (dl_we),
        .dl_idx   (dl_idx),
        .dl_lbase (dl_lbase),
        .dl_mask  (dl_mask),
        .dl_pbase (dl_pbase),
        .dl_asn   (dl_asn),
        .dl_valid (dl_valid),
        .rw_we    (rw_we),
        .rw_sel   (rw_sel),
        .rw_idx   (rw_idx),
        .rw_data  (rw_data),
        .pa_o     (pa_o),
        .hit_o    (hit_o),
        .fault_o  (fault_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string detail);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    task automatic load_desc(input int idx, input logic [ADDR_W-1:0] lb,
                             input logic [ADDR_W-1:0] mk, input logic [ADDR_W-1:0] pb,
                             input logic [ASN_W-1:0] asn, input logic vld);
        dl_idx = IDX_W'(idx); dl_lbase = lb; dl_mask = mk; dl_pbase = pb;
        dl_asn = asn; dl_valid = vld; dl_we = 1'b1;
        @(negedge clk);
        dl_we = 1'b0;
    endtask

    task automatic write_reg(input logic sel, input int idx, input logic [ASN_W-1:0] data);
        rw_sel = sel; rw_idx = IDX_W'(idx); rw_data = data; rw_we = 1'b1;
        @(negedge clk);
        rw_we = 1'b0;
    endtask

    // Issue one lookup and compare outcome, address and latency in cycles.
    task automatic lookup(input logic [ADDR_W-1:0] a, input logic [SC_W-1:0] sp,
                          input bit exp_hit, input logic [ADDR_W-1:0] exp_pa,
                          input int exp_lat, input string tag);
        int lat;
        lk_addr = a; lk_space = sp; lk_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        lat = 1;
        while (!hit_o && !fault_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (exp_hit) begin
            check(hit_o && !fault_o && pa_o == exp_pa && lat == exp_lat, tag,
                  $sformatf("addr=%h actual hit=%0b fault=%0b pa=%h lat=%0d expected hit=1 pa=%h lat=%0d",
                            a, hit_o, fault_o, pa_o, lat, exp_pa, exp_lat));
        end else begin
            check(fault_o && !hit_o && lat == exp_lat, tag,
                  $sformatf("addr=%h actual hit=%0b fault=%0b lat=%0d expected fault=1 lat=%0d",
                            a, hit_o, fault_o, lat, exp_lat));
        end
    endtask

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_addr = '0; lk_space = '0;
        dl_we = 1'b0; dl_idx = '0; dl_lbase = '0; dl_mask = '0; dl_pbase = '0;
        dl_asn = '0; dl_valid = 1'b0;
        rw_we = 1'b0; rw_sel = 1'b0; rw_idx = '0; rw_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of the outputs.
        check(hit_o == 1'b0 && fault_o == 1'b0 && pa_o == '0, "R1",
              $sformatf("actual hit=%0b fault=%0b pa=%h expected 0 0 0", hit_o, fault_o, pa_o));

        // R1/R9: identity through descriptor 0, any space code maps to ASN 0.
        lookup(24'h123456, 3'd5, 1'b1, 24'h123456, 2, "R1 identity scan");
        // R4: same descriptor now answered from the cache.
        lookup(24'hABCDEF, 3'd2, 1'b1, 24'hABCDEF, 1, "R4 identity cached");

        // R7: status write clears descriptor 0 valid; nothing matches -> R5 fault.
        write_reg(1'b0, 0, 8'd0);
        lookup(24'h123456, 3'd0, 1'b0, '0, FAULT_LAT, "R5/R7 fault after invalidate");

        // R2/R8: sweep every remaining slot with a 64K segment each.
        for (int i = 1; i < NUM_DESC; i++)
            load_desc(i, ADDR_W'(i << 16), 24'h00FFFF, ADDR_W'((i ^ 31) << 16), 8'd0, 1'b1);
        for (int i = 1; i < NUM_DESC; i++) begin
            logic [ADDR_W-1:0] off;
            off = ADDR_W'((i * 32'h0731) & 32'hFFFF);
            lookup(ADDR_W'(i << 16) | off, 3'd0, 1'b1,
                   ADDR_W'((i ^ 31) << 16) | off, i + 2, "R2/R8 sweep");
        end

        // R4: repeat hits on the cached slot 31.
        lookup(24'h1F0042, 3'd0, 1'b1, 24'h000042, 1, "R4 cached");
        lookup(24'h1FFFFF, 3'd0, 1'b1, 24'h00FFFF, 1, "R4 cached edge offset");

        // R3: slot 20 now overlaps slot 25; lower index wins.
        load_desc(20, 24'h190000, 24'h00FFFF, 24'h7A0000, 8'd0, 1'b1);
        lookup(24'h190010, 3'd0, 1'b1, 24'h7A0010, 22, "R3 lowest index wins");

        // R5: a fault leaves the cache (slot 7) in place.
        lookup(24'h070005, 3'd0, 1'b1, 24'h180005, 9, "R2 slot 7");
        lookup(24'h800000, 3'd0, 1'b0, '0, FAULT_LAT, "R5 unmapped");
        lookup(24'h07ABCD, 3'd0, 1'b1, 24'h18ABCD, 1, "R5 cache kept after fault");

        // R10: a request raised mid-scan is ignored.
        begin
            bit saw_hit;
            int fault_at;
            saw_hit = 1'b0; fault_at = 0;
            lk_addr = 24'h900000; lk_space = 3'd0; lk_req = 1'b1;
            @(posedge clk);
            for (int n = 1; n <= 36; n++) begin
                @(negedge clk);
                if (hit_o) saw_hit = 1'b1;
                if (fault_o && fault_at == 0) fault_at = n;
                lk_req = (n == 3);
                if (n == 3) lk_addr = 24'h070000;
            end
            lk_req = 1'b0;
            check(!saw_hit && fault_at == FAULT_LAT, "R10",
                  $sformatf("actual saw_hit=%0b fault_at=%0d expected 0 %0d",
                            saw_hit, fault_at, FAULT_LAT));
        end
        lookup(24'h070001, 3'd0, 1'b1, 24'h180001, 1, "R10 cache intact");

        // R9: remap code 3 to ASN 9 (also flushes, R7).
        write_reg(1'b1, 3, 8'd9);
        lookup(24'h070001, 3'd3, 1'b0, '0, FAULT_LAT, "R9 no ASN 9 segment");
        load_desc(30, 24'h070000, 24'h00FFFF, 24'h300000, 8'd9, 1'b1);
        lookup(24'h070001, 3'd3, 1'b1, 24'h300001, 32, "R9 ASN 9 match");
        lookup(24'h070001, 3'd0, 1'b1, 24'h180001, 9, "R9 cached slot wrong ASN");

        // R6: a descriptor load flushes the cache.
        lookup(24'h070002, 3'd0, 1'b1, 24'h180002, 1, "R6 pre cached");
        load_desc(29, 24'h1D0000, 24'h00FFFF, 24'h020000, 8'd0, 1'b1);
        lookup(24'h070002, 3'd0, 1'b1, 24'h180002, 9, "R6 flushed by load");

        // R7: status write and space-table write both flush.
        lookup(24'h070003, 3'd0, 1'b1, 24'h180003, 1, "R7 pre cached");
        write_reg(1'b0, 28, 8'd1);
        lookup(24'h070003, 3'd0, 1'b1, 24'h180003, 9, "R7 flushed by status");
        lookup(24'h070004, 3'd0, 1'b1, 24'h180004, 1, "R7 pre cached 2");
        write_reg(1'b1, 6, 8'd0);
        lookup(24'h070004, 3'd0, 1'b1, 24'h180004, 9, "R7 flushed by space write");

        // R8: narrow mask, OR of physical base and offset, non-offset mismatch.
        load_desc(2, 24'h020000, 24'h0000FF, 24'hC00000, 8'd0, 1'b1);
        lookup(24'h0200AB, 3'd0, 1'b1, 24'hC000AB, 4, "R8 narrow mask");
        lookup(24'h0201AB, 3'd0, 1'b0, '0, FAULT_LAT, "R8 outside narrow segment");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule